// File: doc/BRIEF.md
# Bus Error Address Capture Register

This block watches the live signals of a parallel system bus cycle and records them when that cycle ends in a bus error. It stores all 31 upper address bits, the long-word flag, the two data strobes, the six-bit address modifier and the write/read direction. A host reads the stored record back through one read-only 8-bit register.

Each host read returns one four-bit slice of the record in the low nibble. An internal pointer steps to the next slice after every read. It covers sixteen slices and then wraps. The top bit shows whether the block is armed, meaning it is waiting to catch a bus error. Once a record has been caught, later bus errors leave it alone. Capture is armed again by an explicit clear or when the host finishes reading the whole sequence.

Typical use: a fault handler reads the register sixteen times after a bus error. It rebuilds the faulting address, the byte lanes and the access type, and in doing so re-arms capture for the next fault.

Top module: `berr_capture_reg`

## Requirements
- R1: The read data is laid out as follows. Bit 7 is the armed flag: 1 means waiting for a bus error, 0 means a record is held and capture is idle. Bits 6..4 always read 0. Bits 3..0 carry the current record slice.
- R2: A synchronous active-high reset sets the armed flag, empties the record and puts the pointer on slice 1. Until the first capture the read data is 8'h80, whether or not reads occur.
- R3: When the bus error strobe is high at a clock edge while armed, the block does three things in that one edge: it latches every bus field, clears the armed flag, and moves the pointer to slice 1.
- R4: Slices 1 to 7 return address bits A31..A04, four per slice in descending order, with the highest-numbered bit in bit 3. Slice 8 returns {A03, A02, A01, LWORD}.
- R5: Slice 9 returns {DS1, DS0, AM5, AM4}. Slice 10 returns {AM3, AM2, AM1, AM0}.
- R6: Slice 11 returns {WRITE, 0, 0, 0}. Slices 12 to 16 return 0.
- R7: The slice addressed by the pointer is shown combinationally during a read strobe. The pointer advances by one at the clock edge that ends that strobe. Cycles without a read strobe leave it unchanged.
- R8: The read that follows slice 16 returns slice 1 again. The read of slice 16 sets the armed flag.
- R9: A bus error strobe seen while not armed changes neither the record nor the pointer.
- R10: The clear input sets the armed flag and does not move the pointer. The held record stays readable until the next capture.
- R11: A bus error after re-arming replaces the record and returns the pointer to slice 1.
- R12: All 31 address bits are stored and returned for every address modifier value, including those for 24-bit and 16-bit address cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 31 | Live address bits A31..A01 |
| bus_lword | input | 1 | Live long-word flag |
| bus_ds | input | 2 | Live data strobes, bit 1 is DS1 |
| bus_am | input | 6 | Live address modifier |
| bus_write | input | 1 | Live direction, 1 for write |
| berr | input | 1 | Bus error strobe |
| cap_clear | input | 1 | Re-arm capture |
| host_rd | input | 1 | Single-cycle host read strobe |
| host_rdata | output | 8 | Register read data |

## Verification
Five records are captured and read back in full: all ones, all zeros, two alternating bit patterns carrying 24-bit and 16-bit address modifiers, and an irregular value. The all-ones and all-zeros records expose stuck slice bits. The alternating patterns expose swapped or shifted bits within a slice and a wrong slice order. The irregular value separates neighbouring slices from each other. Further sequences place a second bus error part way through a readout, a clear part way through a readout, and a read after the sixteenth slice. These tell apart record protection, pointer stability and wrap-with-re-arm.

// File: rtl/berr_capture_reg.sv
module berr_capture_reg (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:1] bus_addr,
  input  logic        bus_lword,
  input  logic [1:0]  bus_ds,
  input  logic [5:0]  bus_am,
  input  logic        bus_write,
  input  logic        berr,
  input  logic        cap_clear,
  input  logic        host_rd,
  output logic [7:0]  host_rdata
);
  localparam int NIB_W  = 4;
  localparam int NUM_NIB = 16;
  localparam int REC_W  = NIB_W * NUM_NIB;
  localparam int PTR_W  = $clog2(NUM_NIB);
  localparam int INFO_W = 31 + 1 + 2 + 6 + 1;

  logic [REC_W-1:0] rec;
  logic [PTR_W-1:0] ptr;
  logic             armed;
  logic             held;

  wire take = berr && armed;
  wire last = (ptr == PTR_W'(NUM_NIB - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      rec   <= '0;
      ptr   <= '0;
      armed <= 1'b1;
      held  <= 1'b0;
    end else if (take) begin
      rec   <= {bus_addr, bus_lword, bus_ds, bus_am, bus_write, (REC_W - INFO_W)'(0)};
      ptr   <= '0;
      armed <= 1'b0;
      held  <= 1'b1;
    end else begin
      if (held && host_rd) begin
        ptr <= ptr + 1'b1;
        if (last) armed <= 1'b1;
      end
      if (cap_clear) armed <= 1'b1;
    end
  end

  wire [REC_W-1:0] shifted = rec << (NIB_W * ptr);
  wire [NIB_W-1:0] nibble  = held ? shifted[REC_W-1 -: NIB_W] : '0;

  assign host_rdata = {armed, 3'b000, nibble};

  assert_capture_R3: assert property (@(posedge clk) disable iff (rst)
    (berr && armed) |=> (!armed && held && ptr == '0));

  assert_ptr_step_R7: assert property (@(posedge clk) disable iff (rst)
    (held && host_rd && !berr) |=> (ptr == $past(ptr) + 1'b1));

  assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!host_rd && !(berr && armed)) |=> $stable(ptr));

  assert_wrap_rearm_R8: assert property (@(posedge clk) disable iff (rst)
    (held && !armed && host_rd && ptr == PTR_W'(NUM_NIB - 1)) |=> armed);

  assert_no_overwrite_R9: assert property (@(posedge clk) disable iff (rst)
    (!armed) |=> $stable(rec));

  assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (cap_clear && !(berr && armed)) |=> (armed && $stable(rec)));
endmodule

// File: tb/tb_berr_capture_reg.sv
module tb_berr_capture_reg;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:1] bus_addr;
  logic        bus_lword;
  logic [1:0]  bus_ds;
  logic [5:0]  bus_am;
  logic        bus_write;
  logic        berr;
  logic        cap_clear;
  logic        host_rd;
  logic [7:0]  host_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:1] e_addr;
  logic        e_lword;
  logic [1:0]  e_ds;
  logic [5:0]  e_am;
  logic        e_write;

  always #(CLK_PERIOD/2) clk = ~clk;

  berr_capture_reg dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_lword(bus_lword),
    .bus_ds(bus_ds), .bus_am(bus_am), .bus_write(bus_write), .berr(berr),
    .cap_clear(cap_clear), .host_rd(host_rd), .host_rdata(host_rdata)
  );

  function automatic logic [3:0] exp_nib(input int k);
    logic [31:0] a;
    a = {e_addr, 1'b0};
    if (k < 7)       return a[31 - 4*k -: 4];
    else if (k == 7) return {e_addr[3:1], e_lword};
    else if (k == 8) return {e_ds, e_am[5:4]};
    else if (k == 9) return e_am[3:0];
    else if (k == 10) return {e_write, 3'b000};
    else             return 4'h0;
  endfunction

  function automatic string tag_of(input int k);
    if (k < 8)       return "R4";
    else if (k < 10) return "R5";
    else             return "R6";
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input int k, input logic stat, input string tag);
    host_rd = 1'b1;
    #1;
    chk(host_rdata, {stat, 3'b000, exp_nib(k)}, tag);
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic capture(input logic [31:1] a, input logic l, input logic [1:0] d,
                         input logic [5:0] m, input logic w);
    bus_addr = a; bus_lword = l; bus_ds = d; bus_am = m; bus_write = w;
    berr = 1'b1;
    e_addr = a; e_lword = l; e_ds = d; e_am = m; e_write = w;
    @(negedge clk);
    berr = 1'b0;
    bus_addr = ~a; bus_lword = ~l; bus_ds = ~d; bus_am = ~m; bus_write = ~w;
  endtask

  task automatic full_pattern(input logic [31:1] a, input logic l, input logic [1:0] d,
                              input logic [5:0] m, input logic w, input string pre);
    capture(a, l, d, m, w);
    #1;
    chk(host_rdata, {1'b0, 3'b000, exp_nib(0)}, "R3");
    @(negedge clk);
    #1;
    chk(host_rdata, {1'b0, 3'b000, exp_nib(0)}, "R7");
    @(negedge clk);
    for (int k = 0; k < 16; k++) rd_chk(k, 1'b0, {pre, tag_of(k)});
    rd_chk(0, 1'b1, "R8");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; berr = 1'b0; cap_clear = 1'b0; host_rd = 1'b0;
    bus_addr = '0; bus_lword = 1'b0; bus_ds = 2'b00; bus_am = '0; bus_write = 1'b0;
    e_addr = '0; e_lword = 1'b0; e_ds = 2'b00; e_am = '0; e_write = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(host_rdata, 8'h80, "R2");
    @(negedge clk);
    host_rd = 1'b1; #1; chk(host_rdata, 8'h80, "R2"); @(negedge clk);
    #1; chk(host_rdata, 8'h80, "R2"); host_rd = 1'b0;
    @(negedge clk);

    full_pattern(31'h7FFF_FFFF, 1'b1, 2'b11, 6'h3F, 1'b1, "");
    full_pattern(31'h0000_0000, 1'b0, 2'b00, 6'h00, 1'b0, "");
    // R12: 24-bit and 16-bit address modifiers keep every address bit
    full_pattern(31'h5555_5555, 1'b0, 2'b10, 6'h39, 1'b1, "R12/");
    full_pattern(31'h2AAA_AAAA, 1'b1, 2'b01, 6'h29, 1'b0, "R12/");
    full_pattern(31'h091A_2B3C, 1'b0, 2'b10, 6'h0D, 1'b1, "");

    // R9: a second bus error during readout leaves the record and pointer alone
    capture(31'h1357_9BDF, 1'b1, 2'b01, 6'h2D, 1'b0);
    for (int k = 0; k < 3; k++) rd_chk(k, 1'b0, "R9");
    bus_addr = 31'h0246_8ACE; bus_am = 6'h11; berr = 1'b1;
    @(negedge clk);
    berr = 1'b0;
    for (int k = 3; k < 16; k++) rd_chk(k, 1'b0, "R9");

    // R10: clear re-arms without moving the pointer
    capture(31'h6BCD_1234, 1'b0, 2'b11, 6'h3D, 1'b1);
    for (int k = 0; k < 2; k++) rd_chk(k, 1'b0, "R10");
    cap_clear = 1'b1;
    @(negedge clk);
    cap_clear = 1'b0;
    #1; chk(host_rdata, {1'b1, 3'b000, exp_nib(2)}, "R10");
    @(negedge clk);
    rd_chk(2, 1'b1, "R10");

    // R11: capture after re-arm replaces the record and restarts at slice 1
    capture(31'h3141_5926, 1'b1, 2'b10, 6'h09, 1'b0);
    #1; chk(host_rdata, {1'b0, 3'b000, exp_nib(0)}, "R11");
    @(negedge clk);
    for (int k = 0; k < 16; k++) rd_chk(k, 1'b0, "R11");
    rd_chk(0, 1'b1, "R8");
    rd_chk(1, 1'b1, "R8");

    // R1: reserved bits stay zero across a full sweep of an all-ones record
    capture(31'h7FFF_FFFF, 1'b1, 2'b11, 6'h3F, 1'b1);
    for (int k = 0; k < 16; k++) begin
      host_rd = 1'b1; #1;
      chk({1'b0, host_rdata[6:4], 4'h0}, 8'h00, "R1");
      @(negedge clk);
    end
    host_rd = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule